// File: doc/BRIEF.md
# Select-Coded Clock Divider with Complementary and Half-Rate Outputs

This block takes one input clock and produces three derived clocks: a main divided clock, its logical complement, and a second clock that runs at exactly half the main rate. A four-bit select code picks the division ratio. The ratio is 1, 2, 3, 4, 5, 6 or 8, or the code powers the outputs down. Every flop is clocked by the input clock. For the odd ratios the block also uses the falling edge, so the main output is high for exactly half of its period.

The select code is treated as quasi-static. It is synchronised into the input clock domain and takes effect only when the current main period ends, so a code change never cuts a main pulse short. One code requests frequency multiplication. That mode is not built: the code silences the outputs and raises a flag. An active-high enable releases all three clock outputs to high impedance when it is low. The unsupported-mode flag stays driven at all times.

Top module: `clkdiv_sel`

## Requirements
- R1: Any select code whose two low bits are 00 holds the main, inverted and half-rate outputs low, whatever the two high bits are.
- R2: With select bits [3:2] = 11, low bits 01 give ratio 6, 10 give ratio 8 and 11 give ratio 2.
- R3: With select bits [3:2] = 00 or 10, low bits 01 give ratio 4, 10 give ratio 1 and 11 give ratio 2.
- R4: Code 0110 gives ratio 5 and code 0111 gives ratio 3. For these odd ratios the main output rises one input half-cycle after the period start and stays high for exactly N input half-cycles, which is a 50% duty.
- R5: In every running mode the half-rate output toggles on the input rising edge that starts each main period, so its period is 2N input cycles and its duty is 50%. In power-down it is low.
- R6: While running, the inverted output is the exact complement of the main output. In power-down it is low.
- R7: When the output enable is low, the three clock outputs are high impedance. When it is high, they are driven.
- R8: Code 0101 (multiplication) is not supported. It holds the clock outputs low and drives the unsupported flag high for as long as it is the active code.
- R9: The active-low asynchronous reset clears all state and forces the outputs low. If the select code is steady across the release, the first main rising edge comes on the third input rising edge after the release (two synchroniser stages, then the load).
- R10: A select code reaches the control logic after two input rising edges. It is loaded only on the rising edge that ends the current main period, so the period in progress completes unchanged.
- R11: For an even ratio N the main output is high for the first N/2 input cycles of its period. For ratio 1 it is high during the first half of each input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock; both edges are used |
| rstN | input | 1 | Asynchronous reset, active low |
| selCode | input | 4 | Ratio and power-down select code |
| outEn | input | 1 | Output enable, active high; low releases the clock outputs |
| mainClk | output | 1 | Divided main clock (tri-state) |
| mainClkN | output | 1 | Complement of the main clock; low in power-down (tri-state) |
| halfClk | output | 1 | Clock at half the main rate (tri-state) |
| unsupMode | output | 1 | High while the multiplication code is active |

## Verification
The bench builds the block with its default two-stage synchroniser. This makes the three-edge latency from reset release to the first output edge visible. It also lets a code that changes in the middle of a period reach the control logic before that period ends, which shows that the load waits for the period boundary. The behavioural model tracks the output level on each input half-cycle for all sixteen codes, with the enable both high and low. Direct time measurements confirm the periods and high times for ratios 3, 5 and 8.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int SEL_BITS = 4;
  localparam int RATIO_W  = 4;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PASS = 2'd1,
    MODE_EVEN = 2'd2,
    MODE_ODD  = 2'd3
  } divMode_t;

  typedef struct packed {
    divMode_t           mode;
    logic [RATIO_W-1:0] ratio;
    logic               unsup;
  } divCfg_t;

  // Per-rising-edge strobes from the control to the datapath
  typedef struct packed {
    logic     run;
    logic     periodStart;
    logic     highNext;
    divMode_t mode;
  } divStrobe_t;

  function automatic divCfg_t decodeSel(input logic [SEL_BITS-1:0] code);
    divCfg_t            cfg;
    logic [RATIO_W-1:0] r;
    r         = '0;
    cfg.unsup = 1'b0;
    case (code[3:2])
      2'b11: begin
        case (code[1:0])
          2'b01:   r = RATIO_W'(6);
          2'b10:   r = RATIO_W'(8);
          2'b11:   r = RATIO_W'(2);
          default: r = '0;
        endcase
      end
      2'b01: begin
        case (code[1:0])
          2'b01:   cfg.unsup = 1'b1;
          2'b10:   r = RATIO_W'(5);
          2'b11:   r = RATIO_W'(3);
          default: r = '0;
        endcase
      end
      default: begin
        case (code[1:0])
          2'b01:   r = RATIO_W'(4);
          2'b10:   r = RATIO_W'(1);
          2'b11:   r = RATIO_W'(2);
          default: r = '0;
        endcase
      end
    endcase
    cfg.ratio = r;
    if (r == '0)                cfg.mode = MODE_OFF;
    else if (r == RATIO_W'(1))  cfg.mode = MODE_PASS;
    else if (r[0])              cfg.mode = MODE_ODD;
    else                        cfg.mode = MODE_EVEN;
    return cfg;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = SEL_BITS
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selCode,
  output divStrobe_t       strobe,
  output logic             unsupFlag
);

  localparam int CHAIN_W = SYNC_STAGES * SEL_W;
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [CHAIN_W-1:0] syncChain;
  logic [SEL_W-1:0]   syncLast;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_single
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= selCode;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clkIn or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[CHAIN_W-SEL_W-1:0], selCode};
      end
    end
  endgenerate

  assign syncLast = syncChain[CHAIN_W-1 -: SEL_W];

  logic [RATIO_W-1:0] cnt, cntNext, hiCnt, hiThresh;
  divCfg_t            actCfg, nextCfg;
  logic               boundary, running;

  always_comb begin
    boundary = (cnt == '0);
    nextCfg  = boundary ? decodeSel(syncLast) : actCfg;
    running  = (nextCfg.mode != MODE_OFF);
    if (!running)      cntNext = '0;
    else if (boundary) cntNext = nextCfg.ratio - ONE;
    else               cntNext = cnt - ONE;
    hiCnt    = (nextCfg.ratio + ONE) >> 1;
    hiThresh = nextCfg.ratio - hiCnt;
    strobe.run         = running;
    strobe.periodStart = running && boundary;
    strobe.highNext    = running && (cntNext >= hiThresh);
    strobe.mode        = nextCfg.mode;
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      actCfg    <= '0;
      unsupFlag <= 1'b0;
    end else begin
      cnt       <= cntNext;
      actCfg    <= nextCfg;
      unsupFlag <= nextCfg.unsup;
    end
  end

  AST_CFG_HOLD_MIDPERIOD: assert property (@(posedge clkIn) disable iff (!rstN)
    (cnt != '0) |=> $stable(actCfg)); // R10
  AST_CNT_WITHIN_RATIO: assert property (@(posedge clkIn) disable iff (!rstN)
    (actCfg.mode != MODE_OFF) |-> (cnt < actCfg.ratio)); // R10

endmodule

// File: rtl/clkdiv_path.sv
module clkdiv_path
  import clkdiv_pkg::*;
(
  input  logic       clkIn,
  input  logic       rstN,
  input  divStrobe_t strobe,
  output logic       mainVal,
  output logic       mainInv,
  output logic       halfVal
);

  logic     runQ, riseQ, fallQ, passQ, passF, halfQ;
  divMode_t modeQ;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      modeQ <= MODE_OFF;
      riseQ <= 1'b0;
      passQ <= 1'b0;
      halfQ <= 1'b0;
    end else begin
      runQ  <= strobe.run;
      modeQ <= strobe.mode;
      riseQ <= ((strobe.mode == MODE_EVEN) || (strobe.mode == MODE_ODD)) && strobe.highNext;
      if (strobe.mode == MODE_PASS) passQ <= ~passQ;
      if (!strobe.run)              halfQ <= 1'b0;
      else if (strobe.periodStart)  halfQ <= ~halfQ;
    end
  end

  // Falling-edge copies: stretch odd ratios and form the ratio-1 pulse
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) begin
      fallQ <= 1'b0;
      passF <= 1'b0;
    end else begin
      fallQ <= riseQ;
      passF <= passQ;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_PASS: mainVal = passQ ^ passF;
      MODE_EVEN: mainVal = riseQ;
      MODE_ODD:  mainVal = riseQ & fallQ;
      default:   mainVal = 1'b0;
    endcase
    mainInv = runQ & ~mainVal;
    halfVal = halfQ;
  end

  AST_OFF_QUIET: assert property (@(posedge clkIn) disable iff (!rstN)
    !runQ |-> (!halfQ && !riseQ)); // R1
  AST_HALF_HOLD: assert property (@(posedge clkIn) disable iff (!rstN)
    (strobe.run && !strobe.periodStart) |=> $stable(halfQ)); // R5

endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clkIn,
  input  logic                rstN,
  input  logic [SEL_BITS-1:0] selCode,
  input  logic                outEn,
  output logic                mainClk,
  output logic                mainClkN,
  output logic                halfClk,
  output logic                unsupMode
);

  divStrobe_t strobe;
  logic       mainVal, mainInvVal, halfVal;

  clkdiv_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (SEL_BITS)
  ) u_ctrl (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .selCode  (selCode),
    .strobe   (strobe),
    .unsupFlag(unsupMode)
  );

  clkdiv_path u_path (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .strobe (strobe),
    .mainVal(mainVal),
    .mainInv(mainInvVal),
    .halfVal(halfVal)
  );

  assign mainClk  = outEn ? mainVal    : 1'bz;
  assign mainClkN = outEn ? mainInvVal : 1'bz;
  assign halfClk  = outEn ? halfVal    : 1'bz;

  AST_UNSUP_SILENT: assert property (@(posedge clkIn) disable iff (!rstN)
    unsupMode |-> (!mainVal && !halfVal && !mainInvVal)); // R8
  AST_INV_COMPLEMENT: assert property (@(posedge clkIn) disable iff (!rstN)
    (mainVal || mainInvVal) |-> (mainVal != mainInvVal)); // R6

endmodule

// File: tb/clkdiv_sel_test.sv
`timescale 1ns/1ps
module clkdiv_sel_test;

  logic       clkIn = 1'b0;
  logic       rstN  = 1'b0;
  logic [3:0] sel   = 4'b0011;
  logic       oe    = 1'b1;
  wire        mainClk, mainClkN, halfClk;
  wire        unsupMode;

  pullup (mainClk);
  pullup (mainClkN);
  pullup (halfClk);

  clkdiv_sel uut (
    .clkIn(clkIn), .rstN(rstN), .selCode(sel), .outEn(oe),
    .mainClk(mainClk), .mainClkN(mainClkN), .halfClk(halfClk), .unsupMode(unsupMode)
  );

  always #2.5 clkIn = ~clkIn;

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  // Reference model state, advanced on each input rising edge
  int s1 = 0, s2 = 0, actCode = 0, actN = 0, k = 0;
  bit half = 0;

  function automatic int ratioOf(input int code);
    int lo = code & 3;
    int hi = code >> 2;
    if (lo == 0) return 0;
    if (hi == 3) return (lo == 1) ? 6 : (lo == 2) ? 8 : 2;
    if (hi == 1) return (lo == 1) ? 0 : (lo == 2) ? 5 : 3;
    return (lo == 1) ? 4 : (lo == 2) ? 1 : 2;
  endfunction

  function automatic bit expMain(input int phase);
    int pos = 2 * k + phase;
    if (actN == 0) return 1'b0;
    if (actN == 1) return (phase == 0);
    if (actN % 2 == 0) return (pos < actN);
    return (pos >= 1) && (pos <= actN);
  endfunction

  function automatic string mainTag();
    if (actCode == 5) return "R8";
    if ((actCode & 3) == 0) return "R1";
    if (actN == 3 || actN == 5) return "R4";
    if ((actCode >> 2) == 3) return {"R2", (actN == 1) ? "" : " R11"};
    return {"R3", " R11"};
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkTime(input string tag, input real act, input real exp);
    nChecks++;
    if ((act - exp > 0.01) || (exp - act > 0.01)) begin
      nErr++;
      $display("FAIL %s: actual %0.3f ns expected %0.3f ns", tag, act, exp);
    end
  endtask

  always @(posedge clkIn) begin
    if (!rstN) begin
      s1 = 0; s2 = 0; actCode = 0; actN = 0; k = 0; half = 0;
    end else begin
      if (actN == 0 || k == actN - 1) begin
        actCode = s2;
        actN    = ratioOf(s2);
        k       = 0;
        half    = (actN != 0) ? !half : 1'b0;
      end else begin
        k++;
      end
      s2 = s1;
      s1 = sel;
    end
  end

  task automatic compareAll(input int phase);
    bit m, mi, h;
    if (!rstN) begin
      chk("R9", mainClk, oe ? 1'b0 : 1'b1);
      chk("R9", halfClk, oe ? 1'b0 : 1'b1);
      chk("R9", unsupMode, 1'b0);
      return;
    end
    m  = expMain(phase);
    mi = (actN != 0) ? !m : 1'b0;
    h  = half;
    chk(oe ? mainTag() : "R7", mainClk, oe ? m : 1'b1);
    chk(oe ? "R6" : "R7", mainClkN, oe ? mi : 1'b1);
    chk(oe ? "R5" : "R7", halfClk, oe ? h : 1'b1);
    chk("R8", unsupMode, actCode == 5);
  endtask

  always @(posedge clkIn) begin #1.25; compareAll(0); end
  always @(negedge clkIn) begin #1.25; compareAll(1); end

  task automatic setSel(input logic [3:0] c);
    @(negedge clkIn); #1; sel = c;
  endtask

  task automatic measure(input logic [3:0] c, input real hiExp, input real perExp, input string tag);
    realtime t1, t2, t3, h1, h2;
    setSel(c);
    repeat (30) @(posedge clkIn);
    @(posedge mainClk) t1 = $realtime;
    @(negedge mainClk) t2 = $realtime;
    @(posedge mainClk) t3 = $realtime;
    chkTime(tag, t2 - t1, hiExp);
    chkTime(tag, t3 - t1, perExp);
    @(posedge halfClk) h1 = $realtime;
    @(posedge halfClk) h2 = $realtime;
    chkTime("R5", h2 - h1, 2.0 * perExp);
  endtask

  initial begin
    realtime t1, t2, t3, t4, t5;
    #11 rstN = 1'b1;
    // R9: steady code 0011 (ratio 2) appears on the third rising edge
    @(posedge clkIn); #1.25; chk("R9", mainClk, 1'b0);
    @(posedge clkIn); #1.25; chk("R9", mainClk, 1'b0);
    @(posedge clkIn); #1.25; chk("R9", mainClk, 1'b1);

    for (int c = 0; c < 16; c++) begin
      setSel(4'(c));
      repeat (40) @(posedge clkIn);
    end

    @(negedge clkIn); #1; oe = 1'b0;
    setSel(4'b0111); repeat (30) @(posedge clkIn);
    setSel(4'b0000); repeat (20) @(posedge clkIn);
    @(negedge clkIn); #1; oe = 1'b1;

    measure(4'b0111, 7.5, 15.0, "R4");
    measure(4'b0110, 12.5, 25.0, "R4");
    measure(4'b1110, 20.0, 40.0, "R2 R11");

    // R10: a code change mid-period waits for the period boundary
    @(posedge mainClk) t1 = $realtime;
    repeat (2) @(posedge clkIn);
    #1 sel = 4'b0011;
    @(negedge mainClk) t2 = $realtime;
    @(posedge mainClk) t3 = $realtime;
    chkTime("R10", t2 - t1, 20.0);
    chkTime("R10", t3 - t1, 40.0);
    @(negedge mainClk) t4 = $realtime;
    @(posedge mainClk) t5 = $realtime;
    chkTime("R10", t5 - t3, 10.0);
    chkTime("R10", t4 - t3, 5.0);

    repeat (10) @(posedge clkIn);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

endmodule